// File: doc/BRIEF.md
# Warp-wide integer reduction unit

This execution unit serves a small SIMT core. One custom R-type instruction is issued to every thread lane of a warp at once. Each lane hands in the 32-bit word it read from its first source register. The unit decodes the operation from the funct7 and funct3 fields and folds the words of all active lanes into one value. It then hands that value back for writeback to the destination register of every active lane. The operations are wrap-around sum, signed and unsigned minimum, signed and unsigned maximum, and bitwise AND, OR and XOR.

The combine is a balanced binary tree with one register per tree level. A warp of LANES lanes therefore takes log2(LANES) cycles from issue to result, and the unit accepts a new instruction on every cycle. A lane whose thread-mask bit is clear does not take part. Its slot is filled with the neutral value of the selected operation, and its write enable stays low. An encoding the unit does not define is flagged and produces no writes. LANES must be a power of two and at least 2.

Top module: `warp_reduce_unit`

## Requirements
- R1: The low six bits of funct7 choose the class: 0 sum, 1 minimum, 2 maximum, 3 AND, 4 OR, 5 XOR. Bit 6 of funct7 selects the unsigned form of classes 0 to 2. Sum gives the same value with bit 6 set or clear.
- R2: Sum is the total of the active lane words modulo 2^32.
- R3: Signed minimum and maximum compare the words as two's-complement numbers. For lanes {0xFFFFFFFF, 0, 0xFFFFFFFE, 5}, minimum is 0xFFFFFFFE and maximum is 5.
- R4: Unsigned minimum and maximum compare the words as unsigned numbers. For the same lanes, minimum is 0 and maximum is 0xFFFFFFFF.
- R5: AND, OR and XOR combine the active lane words bit by bit.
- R6: A lane with a clear mask bit is replaced by the neutral value of the operation. That value is 0 for sum, OR and XOR, all ones for AND, the largest value of the compare type for minimum, and the smallest value for maximum.
- R7: With an all-zero mask, the result is that neutral value and out_done rises. out_illegal stays low and out_wen is all zero.
- R8: The encoding is illegal in three cases: funct3 is not 0, funct7[5:0] is above 5, or funct7[6] is set with class 3, 4 or 5. An illegal encoding raises out_illegal together with out_done and keeps out_wen at zero.
- R9: out_done rises exactly log2(LANES) cycles after the cycle in_valid is sampled high. Instructions may arrive on consecutive cycles, and results leave in issue order.
- R10: When out_done is high, every lane slice of out_rd carries the result (lane i sits at bits i*32 upward). out_wen then equals the issue mask for a legal instruction. out_wen is zero in every other cycle.
- R11: While synchronous reset is high, and in the first cycle after it, out_done, out_illegal and out_wen are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Instruction issued this cycle |
| in_funct7 | input | 7 | funct7 field of the instruction |
| in_funct3 | input | 3 | funct3 field of the instruction |
| in_mask | input | LANES | Thread mask, bit i for lane i |
| in_rs1 | input | LANES*32 | Source words, lane i at bits i*32 upward |
| out_rd | output | LANES*32 | Result broadcast to every lane slice |
| out_wen | output | LANES | Per-lane writeback enable |
| out_done | output | 1 | Result of one instruction present |
| out_illegal | output | 1 | Completed instruction had an undefined encoding |

## Verification
Two events meet in one cycle whenever instructions arrive back to back. One instruction retires at the tree output while later ones are accepted at the input and others fill the middle level. An illegal or empty-mask instruction can also sit next to a legal one in the pipe. The bench provokes this with long gap-free streams that mix legal, illegal, partly masked and fully masked instructions. A scoreboard judges each retirement against its own expected value, mask and flag, and checks that the retirement falls exactly log2(LANES) cycles after issue, so any bleed of state between neighbours shows up as a mismatch.

// File: rtl/lrd_pkg.sv
package lrd_pkg;

    // Operation class carried down the reduction tree
    typedef enum logic [2:0] {
        K_SUM = 3'd0,
        K_MIN = 3'd1,
        K_MAX = 3'd2,
        K_AND = 3'd3,
        K_OR  = 3'd4,
        K_XOR = 3'd5
    } kind_e;

    typedef struct packed {
        kind_e kind;
        logic  uns;     // unsigned compare for min/max
    } op_t;

    typedef struct packed {
        logic valid;
        logic illegal;
        op_t  op;
    } ctrl_t;

    localparam op_t OP_NONE = '{kind: K_SUM, uns: 1'b0};

endpackage

// File: rtl/lrd_decode.sv
module lrd_decode
    import lrd_pkg::*;
(
    input  logic [6:0] funct7,
    input  logic [2:0] funct3,
    output op_t        op,
    output logic       illegal
);

    logic bad;

    always_comb begin
        op  = '{kind: K_SUM, uns: funct7[6]};
        bad = (funct3 != 3'd0);
        unique case (funct7[5:0])
            6'd0: op.kind = K_SUM;
            6'd1: op.kind = K_MIN;
            6'd2: op.kind = K_MAX;
            6'd3: begin op.kind = K_AND; bad = bad | funct7[6]; end
            6'd4: begin op.kind = K_OR;  bad = bad | funct7[6]; end
            6'd5: begin op.kind = K_XOR; bad = bad | funct7[6]; end
            default: bad = 1'b1;
        endcase
        if (bad) op = OP_NONE;
        illegal = bad;
    end

endmodule

// File: rtl/lrd_tree_level.sv
module lrd_tree_level
    import lrd_pkg::*;
#(
    parameter  int W     = 32,
    parameter  int N_IN  = 4,
    parameter  int LANES = 4,
    localparam int N_OUT = N_IN / 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  ctrl_t                ctrl_d,
    input  logic [LANES-1:0]     mask_d,
    input  logic [N_IN*W-1:0]    data_d,
    output ctrl_t                ctrl_q,
    output logic [LANES-1:0]     mask_q,
    output logic [N_OUT*W-1:0]   data_q
);

    function automatic logic [W-1:0] pair(input op_t op, input logic [W-1:0] a,
                                          input logic [W-1:0] b);
        logic lt;
        lt = op.uns ? (a < b) : ($signed(a) < $signed(b));
        case (op.kind)
            K_SUM:   return a + b;
            K_MIN:   return lt ? a : b;
            K_MAX:   return lt ? b : a;
            K_AND:   return a & b;
            K_OR:    return a | b;
            K_XOR:   return a ^ b;
            default: return a + b;
        endcase
    endfunction

    logic [N_OUT*W-1:0] nxt;

    always_comb begin
        for (int i = 0; i < N_OUT; i++) begin
            nxt[i*W +: W] = pair(ctrl_d.op, data_d[2*i*W +: W], data_d[(2*i+1)*W +: W]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            mask_q <= '0;
            data_q <= '0;
        end else begin
            ctrl_q <= ctrl_d;
            mask_q <= mask_d;
            data_q <= nxt;
        end
    end

    // R8: an illegal marker never travels without its valid bit
    a_r8_illegal_rides_valid: assert property (@(posedge clk) disable iff (rst)
        ctrl_q.illegal |-> ctrl_q.valid);

endmodule

// File: rtl/warp_reduce_unit.sv
module warp_reduce_unit
    import lrd_pkg::*;
#(
    parameter  int LANES  = 4,
    parameter  int W      = 32,
    localparam int LEVELS = $clog2(LANES),
    localparam int NODES  = 2 * LANES - 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic [6:0]           in_funct7,
    input  logic [2:0]           in_funct3,
    input  logic [LANES-1:0]     in_mask,
    input  logic [LANES*W-1:0]   in_rs1,
    output logic [LANES*W-1:0]   out_rd,
    output logic [LANES-1:0]     out_wen,
    output logic                 out_done,
    output logic                 out_illegal
);

    // Node offset of the first word entering tree level l
    function automatic int node_off(input int l);
        return 2 * LANES - 2 * (LANES >> l);
    endfunction

    function automatic logic [W-1:0] neutral(input op_t op);
        case (op.kind)
            K_AND:   return '1;
            K_MIN:   return op.uns ? {W{1'b1}} : {1'b0, {(W-1){1'b1}}};
            K_MAX:   return op.uns ? {W{1'b0}} : {1'b1, {(W-1){1'b0}}};
            default: return '0;
        endcase
    endfunction

    op_t   dec_op;
    logic  dec_illegal;

    lrd_decode u_decode (
        .funct7  (in_funct7),
        .funct3  (in_funct3),
        .op      (dec_op),
        .illegal (dec_illegal)
    );

    logic [NODES*W-1:0] tree;
    ctrl_t              ctrl_c [LEVELS+1];
    logic [LANES-1:0]   mask_c [LEVELS+1];

    assign ctrl_c[0] = '{valid: in_valid, illegal: in_valid & dec_illegal, op: dec_op};
    assign mask_c[0] = in_mask;

    // Inactive lanes enter the tree as the operation's neutral value
    always_comb begin
        for (int i = 0; i < LANES; i++) begin
            tree[i*W +: W] = in_mask[i] ? in_rs1[i*W +: W] : neutral(dec_op);
        end
    end

    for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
        localparam int NI  = LANES >> l;
        localparam int OFI = node_off(l);
        localparam int OFO = node_off(l + 1);
        lrd_tree_level #(.W(W), .N_IN(NI), .LANES(LANES)) u_level (
            .clk    (clk),
            .rst    (rst),
            .ctrl_d (ctrl_c[l]),
            .mask_d (mask_c[l]),
            .data_d (tree[OFI*W +: NI*W]),
            .ctrl_q (ctrl_c[l+1]),
            .mask_q (mask_c[l+1]),
            .data_q (tree[OFO*W +: (NI/2)*W])
        );
    end

    ctrl_t fin;
    assign fin = ctrl_c[LEVELS];

    assign out_done    = fin.valid;
    assign out_illegal = fin.valid & fin.illegal;
    assign out_wen     = (fin.valid && !fin.illegal) ? mask_c[LEVELS] : '0;
    assign out_rd      = {LANES{tree[(NODES-1)*W +: W]}};

    // ---------------- checks ----------------
    logic [LEVELS-1:0] chk_issue_sh;
    always_ff @(posedge clk) begin
        if (rst) chk_issue_sh <= '0;
        else     chk_issue_sh <= (chk_issue_sh << 1) | LEVELS'(in_valid);
    end

    a_r9_done_latency: assert property (@(posedge clk) disable iff (rst)
        out_done == chk_issue_sh[LEVELS-1]);

    a_r8_illegal_no_write: assert property (@(posedge clk) disable iff (rst)
        out_illegal |-> (out_wen == '0) && out_done);

    a_r10_wen_only_on_done: assert property (@(posedge clk) disable iff (rst)
        (out_wen != '0) |-> out_done && !out_illegal);

    a_r1_unsigned_only_arith: assert property (@(posedge clk) disable iff (rst)
        (fin.valid && !fin.illegal && fin.op.uns) |-> (fin.op.kind inside {K_SUM, K_MIN, K_MAX}));

    a_r11_quiet_after_reset: assert property (@(posedge clk)
        $past(rst) |-> !out_done && !out_illegal && (out_wen == '0));

endmodule

// File: tb/test_warp_reduce_unit.sv
module test_warp_reduce_unit;

    localparam int CLK_PERIOD = 10;
    localparam int LANES      = 4;
    localparam int W          = 32;
    localparam int LAT        = $clog2(LANES);

    typedef logic [W-1:0] lanes_t [LANES];

    typedef struct {
        logic [W-1:0]     val;
        logic [LANES-1:0] wen;
        logic             ill;
        int               due;
        string            tag;
    } exp_t;

    logic                 clk = 1'b0;
    logic                 rst;
    logic                 in_valid;
    logic [6:0]           in_funct7;
    logic [2:0]           in_funct3;
    logic [LANES-1:0]     in_mask;
    logic [LANES*W-1:0]   in_rs1;
    logic [LANES*W-1:0]   out_rd;
    logic [LANES-1:0]     out_wen;
    logic                 out_done;
    logic                 out_illegal;

    warp_reduce_unit #(.LANES(LANES), .W(W)) i_warp_reduce_unit (
        .clk         (clk),
        .rst         (rst),
        .in_valid    (in_valid),
        .in_funct7   (in_funct7),
        .in_funct3   (in_funct3),
        .in_mask     (in_mask),
        .in_rs1      (in_rs1),
        .out_rd      (out_rd),
        .out_wen     (out_wen),
        .out_done    (out_done),
        .out_illegal (out_illegal)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int   cyc = 0;
    int   n_cmp = 0;
    int   n_bad = 0;
    exp_t q[$];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    // Sequential fold written from the requirements
    function automatic exp_t model(input logic [6:0] f7, input logic [2:0] f3,
                                   input logic [LANES-1:0] m, input lanes_t v, input string tag);
        exp_t         e;
        logic [5:0]   cls;
        logic         u;
        bit           seen;
        logic [W-1:0] acc;
        cls  = f7[5:0];
        u    = f7[6];
        seen = 0;
        acc  = '0;
        e.ill = (f3 != 3'd0) || (cls > 6'd5) || (u && cls >= 6'd3);
        for (int i = 0; i < LANES; i++) begin
            if (m[i]) begin
                if (!seen) acc = v[i];
                else begin
                    case (cls)
                        6'd0: acc = acc + v[i];
                        6'd1: if (u ? (v[i] < acc) : ($signed(v[i]) < $signed(acc))) acc = v[i];
                        6'd2: if (u ? (v[i] > acc) : ($signed(v[i]) > $signed(acc))) acc = v[i];
                        6'd3: acc = acc & v[i];
                        6'd4: acc = acc | v[i];
                        6'd5: acc = acc ^ v[i];
                        default: ;
                    endcase
                end
                seen = 1;
            end
        end
        if (!seen) begin
            case (cls)
                6'd1:    acc = u ? 32'hFFFF_FFFF : 32'h7FFF_FFFF;
                6'd2:    acc = u ? 32'h0000_0000 : 32'h8000_0000;
                6'd3:    acc = 32'hFFFF_FFFF;
                default: acc = 32'h0;
            endcase
        end
        e.val = acc;
        e.wen = e.ill ? '0 : m;
        e.due = 0;
        e.tag = tag;
        return e;
    endfunction

    // Driver: called at a falling edge, holds the instruction for one cycle
    task automatic issue(input logic [6:0] f7, input logic [2:0] f3,
                         input logic [LANES-1:0] m, input lanes_t v, input string tag);
        exp_t e;
        e     = model(f7, f3, m, v, tag);
        e.due = cyc + LAT;
        in_valid  = 1'b1;
        in_funct7 = f7;
        in_funct3 = f3;
        in_mask   = m;
        for (int i = 0; i < LANES; i++) in_rs1[i*W +: W] = v[i];
        q.push_back(e);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        in_valid = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    // Monitor: pops the scoreboard as results retire
    always @(negedge clk) begin
        if (!rst) begin
            if (out_done) begin
                if (q.size() == 0) begin
                    chk(1'b0, "R9", "done with nothing pending", 32'(out_done), 32'h0);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    chk(e.due == cyc, "R9", "retire cycle", 32'(cyc), 32'(e.due));
                    chk(out_illegal == e.ill, e.ill ? "R8" : "R7", "illegal flag",
                        32'(out_illegal), 32'(e.ill));
                    chk(out_wen == e.wen, "R10", "write enables", 32'(out_wen), 32'(e.wen));
                    if (!e.ill) begin
                        for (int i = 0; i < LANES; i++) begin
                            chk(out_rd[i*W +: W] == e.val, e.tag, "lane result",
                                out_rd[i*W +: W], e.val);
                        end
                    end
                end
            end else begin
                // R10: no enables, no flag outside a retirement
                if (out_wen != '0 || out_illegal)
                    chk(1'b0, "R10", "enable or flag without done", 32'(out_wen), 32'h0);
                if (q.size() != 0 && q[0].due <= cyc)
                    chk(1'b0, "R9", "missing retirement", 32'(cyc), 32'(q[0].due));
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 20000);
        n_bad++;
        $display("FAIL watchdog: run did not finish, actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        lanes_t sv;
        lanes_t bv;
        lanes_t av;
        lanes_t wv;
        sv = '{32'hFFFF_FFFF, 32'h0, 32'hFFFF_FFFE, 32'h5};
        bv = '{32'hC3A5_0F96, 32'h9E17_6B2D, 32'hF0F0_5A5A, 32'h3C69_E7D1};
        av = '{32'd3, 32'd7, 32'd2, 32'd5};
        wv = '{32'hFFFF_FFFF, 32'h2, 32'h0, 32'h0};

        rst       = 1'b1;
        in_valid  = 1'b0;
        in_funct7 = '0;
        in_funct3 = '0;
        in_mask   = '0;
        in_rs1    = '0;
        repeat (3) @(negedge clk);
        // R11: outputs quiet straight out of reset
        chk(out_done == 1'b0, "R11", "done in reset", 32'(out_done), 32'h0);
        chk(out_illegal == 1'b0, "R11", "illegal in reset", 32'(out_illegal), 32'h0);
        chk(out_wen == '0, "R11", "wen in reset", 32'(out_wen), 32'h0);
        rst = 1'b0;
        @(negedge clk);
        chk(out_done == 1'b0, "R11", "done after reset", 32'(out_done), 32'h0);

        // Directed, gap-free stream
        issue(7'h00, 3'd0, 4'hF, av, "R2");     // 17
        issue(7'h40, 3'd0, 4'hF, av, "R1");     // unsigned-form sum, same 17
        issue(7'h00, 3'd0, 4'hF, wv, "R2");     // wraps to 1
        issue(7'h01, 3'd0, 4'hF, sv, "R3");     // 0xFFFFFFFE
        issue(7'h02, 3'd0, 4'hF, sv, "R3");     // 5
        issue(7'h41, 3'd0, 4'hF, sv, "R4");     // 0
        issue(7'h42, 3'd0, 4'hF, sv, "R4");     // 0xFFFFFFFF
        issue(7'h03, 3'd0, 4'hF, bv, "R5");
        issue(7'h04, 3'd0, 4'hF, bv, "R5");
        issue(7'h05, 3'd0, 4'hF, bv, "R5");
        // R6: partial masks where a wrong neutral value changes the answer
        issue(7'h01, 3'd0, 4'b1010, sv, "R6");  // min(0,5) = 0
        issue(7'h02, 3'd0, 4'b0100, sv, "R6");  // -2 alone
        issue(7'h41, 3'd0, 4'b0101, sv, "R6");  // 0xFFFFFFFE
        issue(7'h42, 3'd0, 4'b0010, sv, "R6");  // 0
        issue(7'h03, 3'd0, 4'b0110, bv, "R6");
        issue(7'h00, 3'd0, 4'b1001, av, "R6");  // 8
        // R8: illegal encodings next to legal ones
        issue(7'h06, 3'd0, 4'hF, av, "R8");
        issue(7'h43, 3'd0, 4'hF, bv, "R8");
        issue(7'h01, 3'd0, 4'hF, sv, "R3");
        issue(7'h3F, 3'd0, 4'hF, av, "R8");
        issue(7'h00, 3'd1, 4'hF, av, "R8");
        issue(7'h45, 3'd0, 4'h3, bv, "R8");
        // R7: empty mask for each class
        issue(7'h00, 3'd0, 4'h0, av, "R7");
        issue(7'h01, 3'd0, 4'h0, sv, "R7");
        issue(7'h41, 3'd0, 4'h0, sv, "R7");
        issue(7'h02, 3'd0, 4'h0, sv, "R7");
        issue(7'h42, 3'd0, 4'h0, sv, "R7");
        issue(7'h03, 3'd0, 4'h0, bv, "R7");
        issue(7'h04, 3'd0, 4'h0, bv, "R7");
        issue(7'h05, 3'd0, 4'h0, bv, "R7");
        idle(4);

        // R9: mixed stream with occasional gaps
        for (int k = 0; k < 80; k++) begin
            lanes_t     rv;
            logic [6:0] codes [10];
            logic [6:0] f7;
            logic [2:0] f3;
            codes = '{7'h00, 7'h40, 7'h01, 7'h41, 7'h02, 7'h42, 7'h03, 7'h04, 7'h05, 7'h44};
            for (int j = 0; j < LANES; j++) begin
                rv[j] = (k % 3 == 0) ? 32'($urandom % 8) - 32'd4 : 32'($urandom);
            end
            f7 = codes[$urandom % 10];
            f3 = ($urandom % 12 == 0) ? 3'd2 : 3'd0;
            issue(f7, f3, 4'($urandom), rv, "R9");
            if (k % 9 == 4) idle(1 + k % 3);
        end
        idle(LAT + 3);
        chk(q.size() == 0, "R9", "pending after drain", 32'(q.size()), 32'h0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule